// File: doc/BRIEF.md
# Two-Port Address-Extension Bus Bridge

This block joins a host I/O bus that has only a few address lines to an external bus whose address space is as wide as the host data word. The host sees two decoded I/O locations. A write to the load location moves the host data word into an internal address register and leaves the external bus untouched. A later access to the transfer location puts the stored word on the external address lines and moves one data word between host and external bus. One external write or read therefore costs two host transactions, and an N-bit data bus reaches 2^N external locations with just two host addresses.

The stored address stays in place until it is loaded again. Any number of transfers can go out at the same address, so a simple parallel device that ignores the address lines can be driven with transfer accesses alone. The external address lines only drive outward. The external data lines can drive in either direction, and the direction follows the host strobe. Each external output group comes with its own drive-enable signal in place of a true tri-state pin, and the host read-data return works the same way.

Top module: `addr_ext_bridge`

## Requirements
- R1: An access is decoded only when `host_cs` is 1 and `host_addr` equals `LOAD_PORT` (default 4'h8) or `XFER_PORT` (default 4'h9). Any other address, or `host_cs` at 0, behaves as idle.
- R2: A write to the load port stores `host_wdata` in the address register at that clock edge. In the same cycle all five enables/strobes (`nb_addr_oe`, `nb_wdata_oe`, `host_rdata_oe`, `nb_wr`, `nb_rd`) stay 0.
- R3: When no transfer-port access is decoded, every enable and strobe is 0 and `nb_addr`, `nb_wdata` and `host_rdata` read all zeros.
- R4: A write to the transfer port sets `nb_addr_oe`, `nb_wdata_oe` and `nb_wr` to 1 in the same cycle. `nb_addr` equals the stored address and `nb_wdata` equals `host_wdata`.
- R5: A read of the transfer port sets `nb_addr_oe`, `nb_rd` and `host_rdata_oe` to 1 with `nb_wdata_oe` at 0. `nb_addr` equals the stored address and `host_rdata` equals `nb_rdata` in the same cycle.
- R6: The address register changes only on a load-port write. Repeated transfers, a read of the load port, idle cycles and unmapped writes leave it unchanged, and later transfers reuse the last stored address.
- R7: Synchronous active-high `rst` clears the address register to zero and holds every enable and strobe at 0 while asserted.
- R8: When `host_wr` and `host_rd` are both 1 on a transfer-port access, the access is a write. `nb_wr` and `nb_rd` are never 1 together.
- R9: The address register and the external address and data buses are `DATA_W` bits wide (default 16), and a full-width word such as 16'hFFFF passes through unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_addr | input | HOST_AW | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Data returned to the host |
| host_rdata_oe | output | 1 | Host read-data drive enable |
| nb_addr | output | DATA_W | External bus address |
| nb_addr_oe | output | 1 | External address drive enable |
| nb_wdata | output | DATA_W | External bus outbound data |
| nb_wdata_oe | output | 1 | External outbound data drive enable |
| nb_rdata | input | DATA_W | External bus inbound data |
| nb_wr | output | 1 | External write strobe |
| nb_rd | output | 1 | External read strobe |

## Verification
The assertions assume the host holds `host_cs`, `host_addr`, the strobes and `host_wdata` steady for a whole clock cycle and changes them only away from the rising edge. They also assume that `rst` is at a known level from the first edge. The bench meets both assumptions: it starts in reset and changes every input just after a falling edge, then holds it for the whole cycle. It then runs load writes, transfer writes and reads, a load-port read, an unmapped write, a deselected load, a cycle with both strobes and a reset in mid-run, one access at a time.

// File: rtl/aeb_pkg.sv
package aeb_pkg;

    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_LOAD = 2'd1,
        PORT_XFER = 2'd2
    } port_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef struct packed {
        logic addr_oe;
        logic wdata_oe;
        logic rdata_oe;
        logic nb_wr;
        logic nb_rd;
    } xfer_ctl_t;

    // A write strobe wins over a simultaneous read strobe.
    function automatic op_e strobe_op(input logic wr, input logic rd);
        if (wr)      return OP_WRITE;
        else if (rd) return OP_READ;
        else         return OP_NONE;
    endfunction

    function automatic xfer_ctl_t ctl_for(input port_e p, input op_e op);
        xfer_ctl_t c;
        c = '0;
        if (p == PORT_XFER) begin
            case (op)
                OP_WRITE: begin
                    c.addr_oe  = 1'b1;
                    c.wdata_oe = 1'b1;
                    c.nb_wr    = 1'b1;
                end
                OP_READ: begin
                    c.addr_oe  = 1'b1;
                    c.rdata_oe = 1'b1;
                    c.nb_rd    = 1'b1;
                end
                default: c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/aeb_port_decode.sv
module aeb_port_decode
    import aeb_pkg::*;
#(
    parameter int                   HOST_AW   = 4,
    parameter logic [HOST_AW-1:0]   LOAD_PORT = 4'h8,
    parameter logic [HOST_AW-1:0]   XFER_PORT = 4'h9
) (
    input  logic               rst,
    input  logic               host_cs,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    output port_e              port,
    output op_e                op,
    output xfer_ctl_t          ctl
);

    always_comb begin
        port = PORT_IDLE;
        if (!rst && host_cs) begin
            if (host_addr == LOAD_PORT)      port = PORT_LOAD;
            else if (host_addr == XFER_PORT) port = PORT_XFER;
        end
        op  = strobe_op(host_wr, host_rd);
        ctl = ctl_for(port, op);
    end

endmodule

// File: rtl/aeb_addr_reg.sv
module aeb_addr_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] areg
);

    always_ff @(posedge clk) begin
        if (rst)          areg <= '0;
        else if (load_en) areg <= load_data;
    end

    // R2: a load captures the host word
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        load_en |=> areg == $past(load_data));

    // R6: without a load the register holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(areg));

    // R7: first cycle out of reset shows zero
    a_r7_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> areg == '0);

endmodule

// File: rtl/aeb_bus_drive.sv
module aeb_bus_drive
    import aeb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_ctl_t         ctl,
    input  logic [DATA_W-1:0] areg,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] nb_rdata,
    output logic [DATA_W-1:0] nb_addr,
    output logic              nb_addr_oe,
    output logic [DATA_W-1:0] nb_wdata,
    output logic              nb_wdata_oe,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_oe,
    output logic              nb_wr,
    output logic              nb_rd
);

    always_comb begin
        nb_addr_oe    = ctl.addr_oe;
        nb_wdata_oe   = ctl.wdata_oe;
        host_rdata_oe = ctl.rdata_oe;
        nb_wr         = ctl.nb_wr;
        nb_rd         = ctl.nb_rd;
        nb_addr       = ctl.addr_oe  ? areg       : '0;
        nb_wdata      = ctl.wdata_oe ? host_wdata : '0;
        host_rdata    = ctl.rdata_oe ? nb_rdata   : '0;
    end

    // R4: a driven external address is the stored register
    a_r4_addr_is_reg: assert property (@(posedge clk) disable iff (rst)
        nb_addr_oe |-> nb_addr == areg);

    // R5: an inbound transfer never drives outbound data
    a_r5_read_dir: assert property (@(posedge clk) disable iff (rst)
        nb_rd |-> (!nb_wdata_oe && host_rdata == nb_rdata));

    // R8: strobes are exclusive
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(nb_wr && nb_rd));

endmodule

// File: rtl/addr_ext_bridge.sv
module addr_ext_bridge
    import aeb_pkg::*;
#(
    parameter int                 HOST_AW   = 4,
    parameter int                 DATA_W    = 16,
    parameter logic [HOST_AW-1:0] LOAD_PORT = 4'h8,
    parameter logic [HOST_AW-1:0] XFER_PORT = 4'h9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_cs,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rdata_oe,
    output logic [DATA_W-1:0]  nb_addr,
    output logic               nb_addr_oe,
    output logic [DATA_W-1:0]  nb_wdata,
    output logic               nb_wdata_oe,
    input  logic [DATA_W-1:0]  nb_rdata,
    output logic               nb_wr,
    output logic               nb_rd
);

    port_e             port;
    op_e               op;
    xfer_ctl_t         ctl;
    logic              load_en;
    logic [DATA_W-1:0] areg;

    aeb_port_decode #(
        .HOST_AW   (HOST_AW),
        .LOAD_PORT (LOAD_PORT),
        .XFER_PORT (XFER_PORT)
    ) u_decode (
        .rst       (rst),
        .host_cs   (host_cs),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .port      (port),
        .op        (op),
        .ctl       (ctl)
    );

    assign load_en = (port == PORT_LOAD) && (op == OP_WRITE);

    aeb_addr_reg #(.DATA_W(DATA_W)) u_areg (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_data (host_wdata),
        .areg      (areg)
    );

    aeb_bus_drive #(.DATA_W(DATA_W)) u_drive (
        .clk           (clk),
        .rst           (rst),
        .ctl           (ctl),
        .areg          (areg),
        .host_wdata    (host_wdata),
        .nb_rdata      (nb_rdata),
        .nb_addr       (nb_addr),
        .nb_addr_oe    (nb_addr_oe),
        .nb_wdata      (nb_wdata),
        .nb_wdata_oe   (nb_wdata_oe),
        .host_rdata    (host_rdata),
        .host_rdata_oe (host_rdata_oe),
        .nb_wr         (nb_wr),
        .nb_rd         (nb_rd)
    );

    // R2: a load cycle leaves the external bus undriven
    a_r2_load_quiet: assert property (@(posedge clk) disable iff (rst)
        (port == PORT_LOAD) |-> !(nb_addr_oe || nb_wdata_oe || host_rdata_oe || nb_wr || nb_rd));

    // R3: idle decode means nothing is driven
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (port == PORT_IDLE) |-> !(nb_addr_oe || nb_wdata_oe || host_rdata_oe || nb_wr || nb_rd));

    // R4: a host write at the transfer port raises both outbound buffer groups
    a_r4_write_enables: assert property (@(posedge clk) disable iff (rst)
        (host_cs && host_addr == XFER_PORT && host_wr) |-> (nb_addr_oe && nb_wdata_oe && nb_wr));

    // R7: nothing drives while reset is high
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |-> !(nb_addr_oe || nb_wdata_oe || host_rdata_oe || nb_wr || nb_rd));

endmodule

// File: tb/addr_ext_bridge_test.sv
`timescale 1ns/1ps
module addr_ext_bridge_test;

    localparam int         AW = 4;
    localparam int         DW = 16;
    localparam logic [3:0] LP = 4'h8;
    localparam logic [3:0] XP = 4'h9;

    typedef struct packed {
        logic          aoe;
        logic [DW-1:0] a;
        logic          woe;
        logic [DW-1:0] w;
        logic          roe;
        logic [DW-1:0] r;
        logic          nwr;
        logic          nrd;
    } obs_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_cs = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdata_oe;
    logic [DW-1:0] nb_addr;
    logic          nb_addr_oe;
    logic [DW-1:0] nb_wdata;
    logic          nb_wdata_oe;
    logic [DW-1:0] nb_rdata = '0;
    logic          nb_wr;
    logic          nb_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    obs_t          exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] mirror = '0;

    always #10 clk = ~clk;

    addr_ext_bridge #(
        .HOST_AW(AW), .DATA_W(DW), .LOAD_PORT(LP), .XFER_PORT(XP)
    ) uut (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .nb_addr(nb_addr), .nb_addr_oe(nb_addr_oe),
        .nb_wdata(nb_wdata), .nb_wdata_oe(nb_wdata_oe),
        .nb_rdata(nb_rdata), .nb_wr(nb_wr), .nb_rd(nb_rd)
    );

    // Driver: applies one host cycle and queues the expected outputs.
    task automatic step(input string tag, input logic r_, input logic cs,
                        input logic [AW-1:0] ad, input logic wr, input logic rd,
                        input logic [DW-1:0] wd, input logic [DW-1:0] nbr);
        obs_t e;
        @(negedge clk);
        #1;
        rst = r_; host_cs = cs; host_addr = ad; host_wr = wr; host_rd = rd;
        host_wdata = wd; nb_rdata = nbr;
        e = '0;
        if (!r_ && cs && ad == XP && (wr || rd)) begin
            e.aoe = 1'b1;
            e.a   = mirror;
            if (wr) begin
                e.woe = 1'b1; e.w = wd; e.nwr = 1'b1;
            end else begin
                e.roe = 1'b1; e.r = nbr; e.nrd = 1'b1;
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (r_) mirror = '0;
        else if (cs && ad == LP && wr) mirror = wd;
    endtask

    // Monitor: compares the settled outputs late in the low phase.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                obs_t  e;
                obs_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {nb_addr_oe, nb_addr, nb_wdata_oe, nb_wdata,
                     host_rdata_oe, host_rdata, nb_wr, nb_rd};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        step("R7 reset hides xfer write", 1, 1, XP, 1, 0, 16'h1357, 16'h0);
        step("R7 reset hides xfer read",  1, 1, XP, 0, 1, 16'h0,    16'h2222);
        step("R1 cs low idle",            0, 0, XP, 1, 0, 16'h4444, 16'h0);
        step("R3 strobes low idle",       0, 1, XP, 0, 0, 16'h4444, 16'h0);
        step("R7 addr zero after reset",  0, 1, XP, 0, 1, 16'h0,    16'h3C3C);
        step("R2 load quiet",             0, 1, LP, 1, 0, 16'hA5C3, 16'h0);
        step("R4 xfer write",             0, 1, XP, 1, 0, 16'h1234, 16'h0);
        step("R6 repeat xfer reuses addr",0, 1, XP, 1, 0, 16'h5678, 16'h0);
        step("R5 xfer read",              0, 1, XP, 0, 1, 16'h0,    16'hBEEF);
        step("R6 load-port read ignored", 0, 1, LP, 0, 1, 16'h1111, 16'h9999);
        step("R6 addr kept after read",   0, 1, XP, 1, 0, 16'h0F0F, 16'h0);
        step("R1 unmapped write ignored", 0, 1, 4'h3, 1, 0, 16'h2468, 16'h0);
        step("R1 addr kept after unmapped",0,1, XP, 0, 1, 16'h0,    16'h7777);
        step("R8 both strobes is write",  0, 1, XP, 1, 1, 16'hCAFE, 16'hDEAD);
        step("R9 load full width",        0, 1, LP, 1, 0, 16'hFFFF, 16'h0);
        step("R9 full width addr",        0, 1, XP, 1, 0, 16'h8001, 16'h0);
        step("R1 deselected load ignored",0, 0, LP, 1, 0, 16'h0001, 16'h0);
        step("R1 addr kept after deselect",0,1, XP, 0, 1, 16'h0,    16'h00FF);
        step("R7 mid-run reset",          1, 1, XP, 1, 0, 16'h3333, 16'h0);
        step("R7 addr cleared",           0, 1, XP, 1, 0, 16'h4321, 16'h0);
        step("R3 idle after run",         0, 0, 4'h0, 0, 0, 16'h0,  16'h0);
        @(negedge clk);
        #8;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule